// File: doc/BRIEF.md
# VRAM Access Slot Sequencer

This block paces the video memory fetches of a scrolling background engine. While the scan is inside an active line segment it runs through a short repeating unit of access slots. In normal resolution the unit has eight slots, and in high resolution it has four. For each of four memory banks the block reads a 4-bit command from that bank's own pattern table and presents it for the current slot. All four banks step together on one shared slot counter. During blanking every bank is held at the idle command.

The block also audits the programmed tables against the layers that use them. Each background layer has an enable, a reduction factor, a colour depth, and a bank choice for its pattern-name fetches and for its character fetches. From these the block works out how many slots per unit the layer needs. It raises a per-bank overload flag when the layers mapped to a bank ask for more slots than one unit holds. It raises a per-layer shortfall flag when the table of the chosen bank does not hold enough slots carrying that layer's fetch codes.

Pattern tables are copied into a working copy only when a unit starts, so a unit never mixes two tables. The controller has two states:

- IDLE (blanking): moves to RUN when `line_start_i` is seen while `active_i` is high.
- RUN: three transitions are possible.
  - RUN→RUN advance: the slot counter steps by one.
  - RUN→RUN restart: on the last slot, or on a new `line_start_i`, the slot counter returns to slot 0 and the tables and mode are reloaded.
  - RUN→IDLE: taken when `active_i` falls.

Top module: `vram_slot_seq`

## Requirements
- R1: A unit holds 8 slots when `hires_i` was 0 at the unit's start and 4 slots when it was 1. After its last slot the counter wraps to slot 0.
- R2: A clock edge that sees `line_start_i` and `active_i` both high puts the sequencer in RUN at slot 0, starting a new unit. The slot then advances by one per clock.
- R3: While `active_i` is low the sequencer is idle. Every bank command reads 4'hF from the clock edge after `active_i` is sampled low, and `line_start_i` is ignored.
- R4: The command of bank b is found at `cmd_o[4*b+3:4*b]`. Bank order is 0=A0, 1=A1, 2=B0, 3=B1. In RUN, that command equals the code at `pat_i[(8*b+s)*4 +: 4]` for the current slot s.
- R5: Codes 0–3 are pattern-name fetches for layers 0–3, codes 4–7 are character fetches for layers 0–3, and 4'hF is idle. Codes 8–14 are reserved and are output as 4'hF.
- R6: A change to `pat_i` is used only from the start of the next unit. A slot later in the current unit still shows the old code.
- R7: The reduction code (2 bits per layer in `layer_red_i`) gives the pattern-name demand per unit: 00 gives 1 slot, 01 gives 2 slots, and 10 or 11 gives 4 slots. Character demand equals that value when `layer_deep_i` is 0 (16 colours) and twice that value when it is 1.
- R8: `overload_o[b]` is high when the summed demand of enabled layers whose pattern-name bank or character bank is b exceeds the unit length. Disabled layers add nothing.
- R9: `shortfall_o[l]` is high for an enabled layer l when either of two conditions holds, counting only slots inside the unit length of the loaded table. The first is that its pattern-name bank holds fewer slots of code l than its pattern-name demand. The second is that its character bank holds fewer slots of code 4+l than its character demand.
- R10: Each bank is budgeted on its own. Moving a layer's fetches from A0 to A1 removes that layer's demand from A0's sum.
- R11: After reset the sequencer is idle, all commands are 4'hF, and the loaded tables are all idle. The mode is normal resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | Strobe marking the start of an active line segment |
| active_i | input | 1 | High during the active display period |
| hires_i | input | 1 | 1 selects the 4-slot unit, 0 the 8-slot unit |
| pat_i | input | 128 | Four pattern tables, 8 slots of 4 bits each, bank-major |
| layer_en_i | input | 4 | Layer enables |
| layer_red_i | input | 8 | Reduction code, 2 bits per layer |
| layer_deep_i | input | 4 | 1 = 256-colour character data (double demand) |
| layer_pn_bank_i | input | 8 | Pattern-name bank per layer, 2 bits each |
| layer_ch_bank_i | input | 8 | Character bank per layer, 2 bits each |
| cmd_o | output | 16 | Current slot command per bank, 4 bits each |
| overload_o | output | 4 | Per-bank demand exceeds unit length |
| shortfall_o | output | 4 | Per-layer table does not cover its demand |

## Verification
The command outputs are combinational from registered state. A line start applied before edge N therefore shows slot 0 just after edge N, and slot k after edge N+k. The bench drives on the falling edge and samples one falling edge later per slot. Blanking shows all-idle commands one edge after `active_i` is sampled low. A table change shows only at the slot-0 edge of the next unit, so the bench counts whole units before looking. The overload and shortfall flags follow the layer settings with no clock delay, but they read the loaded tables and the latched mode. For that reason each budget scenario first starts a unit, then changes only the layer settings and samples at the next falling edge.

// File: rtl/vram_slot_pkg.sv
package vram_slot_pkg;

    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_IDLE = 4'hF;
    localparam logic [CMD_W-1:0] CMD_LAST_FETCH = 4'd7;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_RUN
    } seq_state_e;

    // slots needed per unit for a name fetch, from the reduction code
    function automatic logic [3:0] name_demand(input logic [1:0] red);
        logic [3:0] d;
        unique case (red)
            2'b00:   d = 4'd1;
            2'b01:   d = 4'd2;
            default: d = 4'd4;
        endcase
        return d;
    endfunction

    // character demand doubles for deep colour
    function automatic logic [3:0] char_demand(input logic [1:0] red, input logic deep);
        return deep ? (name_demand(red) << 1) : name_demand(red);
    endfunction

    // reserved codes are presented as idle
    function automatic logic [CMD_W-1:0] clean_cmd(input logic [CMD_W-1:0] c);
        return (c <= CMD_LAST_FETCH) ? c : CMD_IDLE;
    endfunction

endpackage

// File: rtl/vram_slot_ctrl.sv
module vram_slot_ctrl
    import vram_slot_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int HI_SLOTS = MAX_SLOTS / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic              active_i,
    input  logic              hires_i,
    output logic              run_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              load_o,
    output logic              hires_q_o
);

    seq_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              hires_q;
    logic              load;
    logic [SLOT_W-1:0] last_slot;

    assign last_slot = hires_q ? SLOT_W'(HI_SLOTS - 1) : SLOT_W'(MAX_SLOTS - 1);

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        load    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (active_i && line_start_i) begin
                    state_d = SEQ_RUN;
                    slot_d  = '0;
                    load    = 1'b1;
                end
            end
            SEQ_RUN: begin
                if (!active_i) begin
                    state_d = SEQ_IDLE;
                    slot_d  = '0;
                end else if (line_start_i || slot_q == last_slot) begin
                    slot_d = '0;
                    load   = 1'b1;
                end else begin
                    slot_d = slot_q + 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            slot_q  <= '0;
            hires_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            if (load) hires_q <= hires_i;
        end
    end

    always_comb begin
        run_o     = (state_q == SEQ_RUN);
        slot_o    = slot_q;
        load_o    = load;
        hires_q_o = hires_q;
    end

endmodule

// File: rtl/vram_pattern_bank.sv
module vram_pattern_bank
    import vram_slot_pkg::*;
#(
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int TAB_W = MAX_SLOTS * CMD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              run_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [TAB_W-1:0]  pat_i,
    output logic [TAB_W-1:0]  shadow_o,
    output logic [CMD_W-1:0]  cmd_o
);

    logic [TAB_W-1:0] shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shadow_q <= {MAX_SLOTS{CMD_IDLE}};
        else if (load_i) shadow_q <= pat_i;
    end

    always_comb begin
        shadow_o = shadow_q;
        cmd_o    = run_i ? clean_cmd(shadow_q[int'(slot_i)*CMD_W +: CMD_W]) : CMD_IDLE;
    end

endmodule

// File: rtl/vram_budget_check.sv
module vram_budget_check
    import vram_slot_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_LAYERS = 4,
    parameter int MAX_SLOTS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int TAB_W = MAX_SLOTS * CMD_W
) (
    input  logic [NUM_BANKS*TAB_W-1:0]   shadow_i,
    input  logic                         hires_q_i,
    input  logic [NUM_LAYERS-1:0]        layer_en_i,
    input  logic [2*NUM_LAYERS-1:0]      layer_red_i,
    input  logic [NUM_LAYERS-1:0]        layer_deep_i,
    input  logic [BANK_W*NUM_LAYERS-1:0] layer_pn_bank_i,
    input  logic [BANK_W*NUM_LAYERS-1:0] layer_ch_bank_i,
    output logic [NUM_BANKS-1:0]         overload_o,
    output logic [NUM_LAYERS-1:0]        shortfall_o
);

    int          unit_len;
    logic [3:0]  pn_dem  [NUM_LAYERS];
    logic [3:0]  ch_dem  [NUM_LAYERS];
    logic [BANK_W-1:0] pn_bank [NUM_LAYERS];
    logic [BANK_W-1:0] ch_bank [NUM_LAYERS];

    assign unit_len = hires_q_i ? MAX_SLOTS / 2 : MAX_SLOTS;

    for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
        int pn_cnt;
        int ch_cnt;

        always_comb begin
            pn_dem[l]  = name_demand(layer_red_i[2*l +: 2]);
            ch_dem[l]  = char_demand(layer_red_i[2*l +: 2], layer_deep_i[l]);
            pn_bank[l] = layer_pn_bank_i[BANK_W*l +: BANK_W];
            ch_bank[l] = layer_ch_bank_i[BANK_W*l +: BANK_W];
        end

        always_comb begin
            pn_cnt = 0;
            ch_cnt = 0;
            for (int s = 0; s < MAX_SLOTS; s++) begin
                if (s < unit_len) begin
                    if (shadow_i[(int'(pn_bank[l])*MAX_SLOTS + s)*CMD_W +: CMD_W] == CMD_W'(l))
                        pn_cnt++;
                    if (shadow_i[(int'(ch_bank[l])*MAX_SLOTS + s)*CMD_W +: CMD_W] == CMD_W'(NUM_LAYERS + l))
                        ch_cnt++;
                end
            end
            shortfall_o[l] = layer_en_i[l] &&
                             ((pn_cnt < int'(pn_dem[l])) || (ch_cnt < int'(ch_dem[l])));
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        int load_sum;

        always_comb begin
            load_sum = 0;
            for (int l = 0; l < NUM_LAYERS; l++) begin
                if (layer_en_i[l] && pn_bank[l] == BANK_W'(b)) load_sum += int'(pn_dem[l]);
                if (layer_en_i[l] && ch_bank[l] == BANK_W'(b)) load_sum += int'(ch_dem[l]);
            end
            overload_o[b] = (load_sum > unit_len);
        end
    end

endmodule

// File: rtl/vram_slot_seq.sv
module vram_slot_seq
    import vram_slot_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_LAYERS = 4,
    parameter int MAX_SLOTS = 8,
    localparam int BANK_W = $clog2(NUM_BANKS),
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int TAB_W = MAX_SLOTS * CMD_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         line_start_i,
    input  logic                         active_i,
    input  logic                         hires_i,
    input  logic [NUM_BANKS*TAB_W-1:0]   pat_i,
    input  logic [NUM_LAYERS-1:0]        layer_en_i,
    input  logic [2*NUM_LAYERS-1:0]      layer_red_i,
    input  logic [NUM_LAYERS-1:0]        layer_deep_i,
    input  logic [BANK_W*NUM_LAYERS-1:0] layer_pn_bank_i,
    input  logic [BANK_W*NUM_LAYERS-1:0] layer_ch_bank_i,
    output logic [NUM_BANKS*CMD_W-1:0]   cmd_o,
    output logic [NUM_BANKS-1:0]         overload_o,
    output logic [NUM_LAYERS-1:0]        shortfall_o
);

    logic                       run_w;
    logic [SLOT_W-1:0]          slot_w;
    logic                       load_w;
    logic                       hires_w;
    logic [NUM_BANKS*TAB_W-1:0] shadow_w;

    vram_slot_ctrl #(.MAX_SLOTS(MAX_SLOTS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .active_i     (active_i),
        .hires_i      (hires_i),
        .run_o        (run_w),
        .slot_o       (slot_w),
        .load_o       (load_w),
        .hires_q_o    (hires_w)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vram_pattern_bank #(.MAX_SLOTS(MAX_SLOTS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_w),
            .run_i    (run_w),
            .slot_i   (slot_w),
            .pat_i    (pat_i[b*TAB_W +: TAB_W]),
            .shadow_o (shadow_w[b*TAB_W +: TAB_W]),
            .cmd_o    (cmd_o[b*CMD_W +: CMD_W])
        );
    end

    vram_budget_check #(
        .NUM_BANKS  (NUM_BANKS),
        .NUM_LAYERS (NUM_LAYERS),
        .MAX_SLOTS  (MAX_SLOTS)
    ) u_budget (
        .shadow_i        (shadow_w),
        .hires_q_i       (hires_w),
        .layer_en_i      (layer_en_i),
        .layer_red_i     (layer_red_i),
        .layer_deep_i    (layer_deep_i),
        .layer_pn_bank_i (layer_pn_bank_i),
        .layer_ch_bank_i (layer_ch_bank_i),
        .overload_o      (overload_o),
        .shortfall_o     (shortfall_o)
    );

endmodule

// File: rtl/vram_slot_seq_chk.sv
module vram_slot_seq_chk #(
    parameter int NUM_BANKS = 4,
    parameter int MAX_SLOTS = 8,
    localparam int SLOT_W = $clog2(MAX_SLOTS),
    localparam int TAB_W = MAX_SLOTS * 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       line_start_i,
    input logic                       active_i,
    input logic                       run_q,
    input logic [SLOT_W-1:0]          slot_q,
    input logic                       hires_q,
    input logic [NUM_BANKS*TAB_W-1:0] shadow,
    input logic [NUM_BANKS*4-1:0]     cmd_o
);

    logic mid_unit;
    assign mid_unit = run_q && active_i && !line_start_i &&
                      (int'(slot_q) != (hires_q ? MAX_SLOTS / 2 : MAX_SLOTS) - 1);

    AST_SLOT_IN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (int'(slot_q) < (hires_q ? MAX_SLOTS / 2 : MAX_SLOTS))); // R1

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && active_i) |=> (run_q && slot_q == '0)); // R2

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mid_unit |=> (slot_q == $past(slot_q) + 1'b1)); // R2

    AST_BLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!run_q && cmd_o == {NUM_BANKS{4'hF}})); // R3

    AST_TABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mid_unit |=> $stable(shadow)); // R6

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_legal
        AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_o[4*b +: 4] <= 4'd7 || cmd_o[4*b +: 4] == 4'hF)); // R5
    end

endmodule

bind vram_slot_seq vram_slot_seq_chk #(
    .NUM_BANKS (NUM_BANKS),
    .MAX_SLOTS (MAX_SLOTS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .active_i     (active_i),
    .run_q        (run_w),
    .slot_q       (slot_w),
    .hires_q      (hires_w),
    .shadow       (shadow_w),
    .cmd_o        (cmd_o)
);

// File: tb/vram_slot_seq_bench.sv
module vram_slot_seq_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start_i = 1'b0;
    logic         active_i = 1'b0;
    logic         hires_i = 1'b0;
    logic [127:0] pat_i = '1;
    logic [3:0]   layer_en_i = '0;
    logic [7:0]   layer_red_i = '0;
    logic [3:0]   layer_deep_i = '0;
    logic [7:0]   layer_pn_bank_i = '0;
    logic [7:0]   layer_ch_bank_i = '0;
    logic [15:0]  cmd_o;
    logic [3:0]   overload_o;
    logic [3:0]   shortfall_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vram_slot_seq u_vram_slot_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start_i    (line_start_i),
        .active_i        (active_i),
        .hires_i         (hires_i),
        .pat_i           (pat_i),
        .layer_en_i      (layer_en_i),
        .layer_red_i     (layer_red_i),
        .layer_deep_i    (layer_deep_i),
        .layer_pn_bank_i (layer_pn_bank_i),
        .layer_ch_bank_i (layer_ch_bank_i),
        .cmd_o           (cmd_o),
        .overload_o      (overload_o),
        .shortfall_o     (shortfall_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pat(input int b, input int s, input logic [3:0] code);
        pat_i[(b*8 + s)*4 +: 4] = code;
    endtask

    function automatic logic [15:0] row(input int s);
        logic [15:0] r;
        for (int b = 0; b < 4; b++) r[b*4 +: 4] = pat_i[(b*8 + s)*4 +: 4];
        return r;
    endfunction

    task automatic start_unit();
        @(negedge clk);
        line_start_i = 1'b1;
        active_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
    endtask

    task automatic go_idle();
        @(negedge clk);
        active_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill_ramp();
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 8; s++) set_pat(b, s, 4'((b + s) % 8));
    endtask

    task automatic t_reset();
        check("R11 idle cmds", 32'(cmd_o), 32'hFFFF);
        check("R11 overload", 32'(overload_o), 0);
        check("R11 shortfall", 32'(shortfall_o), 0);
    endtask

    task automatic t_normal();
        logic [15:0] exp_row [8];
        hires_i = 1'b0;
        fill_ramp();
        for (int s = 0; s < 8; s++) exp_row[s] = row(s);
        start_unit();
        for (int k = 0; k < 10; k++) begin
            check($sformatf("R1 R2 R4 normal slot %0d", k), 32'(cmd_o), 32'(exp_row[k % 8]));
            @(negedge clk);
        end
        go_idle();
    endtask

    task automatic t_hires();
        logic [15:0] exp_row [4];
        hires_i = 1'b1;
        fill_ramp();
        for (int s = 0; s < 4; s++) exp_row[s] = row(s);
        start_unit();
        for (int k = 0; k < 6; k++) begin
            check($sformatf("R1 hires slot %0d", k), 32'(cmd_o), 32'(exp_row[k % 4]));
            @(negedge clk);
        end
        go_idle();
        hires_i = 1'b0;
    endtask

    task automatic t_reserved();
        fill_ramp();
        set_pat(3, 0, 4'h9);
        set_pat(3, 1, 4'hE);
        set_pat(3, 2, 4'h7);
        start_unit();
        check("R5 code 9 idle", 32'(cmd_o[15:12]), 32'hF);
        @(negedge clk);
        check("R5 code E idle", 32'(cmd_o[15:12]), 32'hF);
        @(negedge clk);
        check("R5 code 7 kept", 32'(cmd_o[15:12]), 32'h7);
        go_idle();
    endtask

    task automatic t_shadow();
        fill_ramp();
        set_pat(0, 3, 4'h1);
        start_unit();
        @(negedge clk);
        set_pat(0, 3, 4'h6);
        @(negedge clk);
        @(negedge clk);
        check("R6 old code mid unit", 32'(cmd_o[3:0]), 32'h1);
        repeat (8) @(negedge clk);
        check("R6 new code next unit", 32'(cmd_o[3:0]), 32'h6);
        go_idle();
    endtask

    task automatic t_blank();
        fill_ramp();
        start_unit();
        @(negedge clk);
        active_i = 1'b0;
        @(negedge clk);
        check("R3 blank idle", 32'(cmd_o), 32'hFFFF);
        line_start_i = 1'b1;
        @(negedge clk);
        line_start_i = 1'b0;
        check("R3 strobe ignored", 32'(cmd_o), 32'hFFFF);
        @(negedge clk);
        check("R3 still idle", 32'(cmd_o), 32'hFFFF);
    endtask

    task automatic t_overload();
        hires_i = 1'b0;
        layer_en_i = 4'b0011;
        layer_red_i = 8'b0000_1010;
        layer_deep_i = 4'b0000;
        layer_pn_bank_i = 8'h00;
        layer_ch_bank_i = 8'h00;
        start_unit();
        check("R8 R7 bank A0 over 16>8", 32'(overload_o), 32'b0001);
        layer_pn_bank_i = 8'b0000_0100;
        layer_ch_bank_i = 8'b0000_0100;
        @(negedge clk);
        check("R10 split A0/A1 fits", 32'(overload_o), 32'b0000);
        check("R8 disabled layer ignored", 32'(overload_o), 32'b0000);
        layer_en_i = 4'b0111;
        @(negedge clk);
        check("R8 enabled layer adds 10>8", 32'(overload_o), 32'b0001);
        go_idle();
        hires_i = 1'b1;
        layer_en_i = 4'b0011;
        layer_red_i = 8'b0000_0100;
        layer_deep_i = 4'b0010;
        layer_pn_bank_i = 8'h00;
        layer_ch_bank_i = 8'h00;
        start_unit();
        check("R1 R8 R7 hires 8>4", 32'(overload_o), 32'b0001);
        layer_pn_bank_i = 8'b0000_1100;
        layer_ch_bank_i = 8'b0000_1100;
        @(negedge clk);
        check("R10 B1 6>4 only", 32'(overload_o), 32'b1000);
        go_idle();
        hires_i = 1'b0;
        layer_en_i = '0;
    endtask

    task automatic t_shortfall();
        pat_i = '1;
        set_pat(2, 0, 4'h0);
        set_pat(2, 1, 4'h4);
        set_pat(2, 2, 4'h0);
        set_pat(2, 3, 4'h4);
        layer_en_i = 4'b0001;
        layer_red_i = 8'b0000_0001;
        layer_deep_i = 4'b0000;
        layer_pn_bank_i = 8'b0000_0010;
        layer_ch_bank_i = 8'b0000_0010;
        start_unit();
        check("R9 covered", 32'(shortfall_o), 32'b0000);
        layer_deep_i = 4'b0001;
        @(negedge clk);
        check("R9 R7 deep char short", 32'(shortfall_o), 32'b0001);
        layer_deep_i = 4'b0000;
        layer_red_i = 8'b0000_0010;
        @(negedge clk);
        check("R9 R7 quarter name short", 32'(shortfall_o), 32'b0001);
        layer_red_i = 8'b0000_0001;
        layer_ch_bank_i = 8'b0000_0001;
        @(negedge clk);
        check("R9 wrong char bank", 32'(shortfall_o), 32'b0001);
        go_idle();
        layer_en_i = '0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_hires();
        t_reserved();
        t_shadow();
        t_blank();
        t_overload();
        t_shortfall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule